// File: doc/BRIEF.md
# Reversible Cascade Self-Test Checker

This block runs an offline self-test on a short programmable cascade of reversible gates acting on a handful of wires. Each gate is one program word that selects an inverter, a controlled inverter, a doubly controlled inverter or a controlled swap, together with the wires it acts on. Every one of these gates undoes itself. So the inverse of the whole cascade is the same list of words evaluated from the last gate back to the first.

After a start pulse, an internal sequencer steps through a reduced set of test vectors that leaves out the trivial patterns. Each vector is loaded onto the wires and pushed through the cascade one gate per clock: first in list order, then in reverse order. The final wire state is then XORed with the vector that was applied. A zero difference means the round trip restored the input. Any set bit marks a fault. For each vector the block emits one result strobe carrying the vector, the difference word and a fault flag. A sticky fault bit summarises the whole run.

A fault-injection input XORs a chosen mask into the wire state right after a chosen gate in a chosen pass. This lets single-bit and multi-bit upsets be modelled without changing the program.

Top module: `rcs_selftest`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `res_valid`, `done` and `fault_sticky` are 0.
- R2: The applied vectors run in ascending order from 2 up to 2^WIRES-2, one result each. The all-zero pattern, the pattern 1 and the all-ones pattern are never applied. With 3 wires this gives 010, 011, 100, 101, 110.
- R3: Gate word layout, low bits first: kind in bits [1:0], then target, then control A, then operand B, each index IDX_W bits wide. Kind 0 inverts the target. Kind 1 XORs wire A into the target. Kind 2 XORs (A AND B) into the target. Kind 3 swaps the target and wire B when wire A is 1.
- R4: Each vector passes through gates 0..N-1 and then N-1..0. With injection disabled, a program whose controls differ from their targets yields a zero difference and a cleared flag for every vector.
- R5: `res_diff` equals the final wire state XOR the applied vector. `res_flag` is 1 exactly when `res_diff` is nonzero.
- R6: When injection is enabled, `inj_mask` is XORed into the wire state right after gate `inj_gate` of the pass chosen by `inj_rev` (0 forward, 1 reverse). When injection is disabled, or `inj_gate` is not below the gate count, the injection inputs have no effect.
- R7: `fault_sticky` is set by any flagged result, holds through the run and is cleared by an accepted start.
- R8: `done` pulses for one cycle together with the result of the last vector. `busy` is low in that cycle.
- R9: Consecutive results are 2*N+1 cycles apart for N gates. A gate count of 0 is legal and gives one result per cycle, each with a zero difference.
- R10: A start pulse while `busy` is high is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a self-test run (accepted only when idle) |
| gate_cnt | input | CNT_W | Number of active gates, clamped to MAX_GATES, latched at start |
| prog_words | input | MAX_GATES*WORD_W | Gate program, word g at bits [g*WORD_W +: WORD_W] |
| inj_en | input | 1 | Enable fault injection |
| inj_gate | input | GI_W | Gate index after which the mask is applied |
| inj_rev | input | 1 | Pass for injection: 0 forward, 1 reverse |
| inj_mask | input | WIRES | Bits flipped in the wire state |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | Per-vector result strobe |
| res_vec | output | WIRES | Vector that was applied |
| res_diff | output | WIRES | Final state XOR applied vector |
| res_flag | output | 1 | Fault detected for this vector |
| done | output | 1 | Pulse with the last result |
| fault_sticky | output | 1 | Any fault seen in the current or last run |

## Verification
The assertions assume that the program, the gate count and the injection inputs stay stable during a run, and that every wire index in the program lies below WIRES. Only under those conditions do the step bound and the per-vector results follow from the latched program. The bench changes these inputs only between runs. Its random gates use three distinct wires, so a control never equals its own target, which keeps each gate self-inverse. Random injection picks gate indices both inside and beyond the programmed count, with random masks, in either pass.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic [1:0] {
      GK_INV   = 2'd0,
      GK_CX    = 2'd1,
      GK_CCX   = 2'd2,
      GK_CSWAP = 2'd3
   } gate_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_RPT  = 2'd2
   } phase_e;
endpackage

// File: rtl/rcs_gate_eval.sv
module rcs_gate_eval #(
   parameter int WIRES = 4,
   parameter int IDX_W = 2
) (
   input  logic [WIRES-1:0] cur,
   input  logic [1:0]       kind,
   input  logic [IDX_W-1:0] tgt,
   input  logic [IDX_W-1:0] opa,
   input  logic [IDX_W-1:0] opb,
   output logic [WIRES-1:0] nxt
);
   import rcs_pkg::*;
   localparam int PAD = 1 << IDX_W;

   if (PAD < WIRES) begin : g_bad_idx
      $error("rcs_gate_eval: IDX_W too small for WIRES");
   end

   // zero-padded copy so any index reads a defined bit
   logic [PAD-1:0] pad;
   logic           bit_a, bit_b, bit_t;
   gate_kind_e     k;

   assign pad   = PAD'(cur);
   assign bit_a = pad[opa];
   assign bit_b = pad[opb];
   assign bit_t = pad[tgt];
   assign k     = gate_kind_e'(kind);

   for (genvar w = 0; w < WIRES; w++) begin : g_wire
      logic nb;
      always_comb begin
         nb = cur[w];
         unique case (k)
            GK_INV:   if (tgt == IDX_W'(w)) nb = ~cur[w];
            GK_CX:    if (tgt == IDX_W'(w)) nb = cur[w] ^ bit_a;
            GK_CCX:   if (tgt == IDX_W'(w)) nb = cur[w] ^ (bit_a & bit_b);
            GK_CSWAP: begin
               if (bit_a) begin
                  if (tgt == IDX_W'(w))      nb = bit_b;
                  else if (opb == IDX_W'(w)) nb = bit_t;
               end
            end
            default: nb = cur[w];
         endcase
      end
      assign nxt[w] = nb;
   end
endmodule

// File: rtl/rcs_vec_gen.sv
module rcs_vec_gen #(
   parameter int WIRES        = 4,
   parameter bit SKIP_TRIVIAL = 1'b1
) (
   output logic [WIRES-1:0] first_vec,
   output logic [WIRES-1:0] last_vec
);
   if (WIRES < 2) begin : g_bad_w
      $error("rcs_vec_gen: at least two wires needed");
   end

   if (SKIP_TRIVIAL) begin : g_skip
      // leave out 0, 1 and all-ones
      assign first_vec = WIRES'(2);
      assign last_vec  = {{(WIRES-1){1'b1}}, 1'b0};
   end else begin : g_full
      assign first_vec = '0;
      assign last_vec  = '1;
   end
endmodule

// File: rtl/rcs_step_ctrl.sv
module rcs_step_ctrl #(
   parameter int MAX_GATES = 8,
   parameter int CNT_W     = 4,
   parameter int STEP_W    = 5,
   parameter int GI_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CNT_W-1:0]  gate_cnt,
   input  logic              at_last,
   output logic              idle,
   output logic              run,
   output logic              rpt,
   output logic [GI_W-1:0]   gidx,
   output logic              rev
);
   import rcs_pkg::*;

   if ((1 << STEP_W) <= 2*MAX_GATES) begin : g_bad_step
      $error("rcs_step_ctrl: STEP_W too narrow");
   end

   phase_e            ph;
   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] span;
   logic [CNT_W-1:0]  cnt_in;
   logic              last_step;

   assign cnt_in    = (gate_cnt > CNT_W'(MAX_GATES)) ? CNT_W'(MAX_GATES) : gate_cnt;
   assign span      = STEP_W'(cnt_q) << 1;
   assign last_step = (step == span - STEP_W'(1));
   assign rev       = (step >= STEP_W'(cnt_q));
   assign gidx      = rev ? GI_W'(span - STEP_W'(1) - step) : GI_W'(step);
   assign idle      = (ph == PH_IDLE);
   assign run       = (ph == PH_RUN);
   assign rpt       = (ph == PH_RPT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt_q <= '0;
         step  <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (go) begin
               cnt_q <= cnt_in;
               step  <= '0;
               ph    <= (cnt_in == '0) ? PH_RPT : PH_RUN;
            end
            PH_RUN: begin
               if (last_step) ph <= PH_RPT;
               else           step <= step + STEP_W'(1);
            end
            PH_RPT: begin
               step <= '0;
               if (at_last)           ph <= PH_IDLE;
               else if (cnt_q == '0)  ph <= PH_RPT;
               else                   ph <= PH_RUN;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R9: the step counter never leaves the two-pass window
   assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RUN) |-> (step < span));
endmodule

// File: rtl/rcs_selftest.sv
module rcs_selftest #(
   parameter int WIRES        = 4,
   parameter int MAX_GATES    = 8,
   parameter bit SKIP_TRIVIAL = 1'b1,
   localparam int IDX_W  = (WIRES > 1) ? $clog2(WIRES) : 1,
   localparam int WORD_W = 2 + 3*IDX_W,
   localparam int CNT_W  = $clog2(MAX_GATES + 1),
   localparam int GI_W   = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1,
   localparam int STEP_W = $clog2(2*MAX_GATES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [CNT_W-1:0]            gate_cnt,
   input  logic [MAX_GATES*WORD_W-1:0] prog_words,
   input  logic                        inj_en,
   input  logic [GI_W-1:0]             inj_gate,
   input  logic                        inj_rev,
   input  logic [WIRES-1:0]            inj_mask,
   output logic                        busy,
   output logic                        res_valid,
   output logic [WIRES-1:0]            res_vec,
   output logic [WIRES-1:0]            res_diff,
   output logic                        res_flag,
   output logic                        done,
   output logic                        fault_sticky
);
   if (MAX_GATES < 1) begin : g_bad_gates
      $error("rcs_selftest: MAX_GATES must be positive");
   end

   logic [WIRES-1:0]  first_vec, last_vec;
   logic              idle, run, rpt, rev, go, inj_hit;
   logic [GI_W-1:0]   gidx;
   logic [WIRES-1:0]  vec_q, wstate_q, gate_out, step_next, diff_now;
   logic [WORD_W-1:0] word;

   assign go   = start && idle;
   assign busy = !idle;
   assign word = prog_words[gidx*WORD_W +: WORD_W];

   rcs_vec_gen #(.WIRES(WIRES), .SKIP_TRIVIAL(SKIP_TRIVIAL)) vec_gen_i (
      .first_vec (first_vec),
      .last_vec  (last_vec)
   );

   rcs_step_ctrl #(.MAX_GATES(MAX_GATES), .CNT_W(CNT_W), .STEP_W(STEP_W),
                   .GI_W(GI_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .gate_cnt (gate_cnt),
      .at_last  (vec_q == last_vec),
      .idle     (idle),
      .run      (run),
      .rpt      (rpt),
      .gidx     (gidx),
      .rev      (rev)
   );

   rcs_gate_eval #(.WIRES(WIRES), .IDX_W(IDX_W)) eval_i (
      .cur  (wstate_q),
      .kind (word[1:0]),
      .tgt  (word[2 +: IDX_W]),
      .opa  (word[2+IDX_W +: IDX_W]),
      .opb  (word[2+2*IDX_W +: IDX_W]),
      .nxt  (gate_out)
   );

   assign inj_hit   = inj_en && run && (gidx == inj_gate) && (rev == inj_rev);
   assign step_next = gate_out ^ (inj_hit ? inj_mask : '0);
   assign diff_now  = wstate_q ^ vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q        <= '0;
         wstate_q     <= '0;
         res_valid    <= 1'b0;
         res_vec      <= '0;
         res_diff     <= '0;
         res_flag     <= 1'b0;
         done         <= 1'b0;
         fault_sticky <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         done      <= 1'b0;
         if (go) begin
            vec_q        <= first_vec;
            wstate_q     <= first_vec;
            fault_sticky <= 1'b0;
         end else if (run) begin
            wstate_q <= step_next;
         end else if (rpt) begin
            res_valid    <= 1'b1;
            res_vec      <= vec_q;
            res_diff     <= diff_now;
            res_flag     <= |diff_now;
            fault_sticky <= fault_sticky | (|diff_now);
            if (vec_q == last_vec) begin
               done <= 1'b1;
            end else begin
               vec_q    <= vec_q + WIRES'(1);
               wstate_q <= vec_q + WIRES'(1);
            end
         end
      end
   end

   // R2: reported vectors stay inside the non-trivial window
   assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_vec >= first_vec && res_vec <= last_vec));
   // R7: a flagged result is always reflected in the sticky bit
   assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_flag) |-> fault_sticky);
   // R8: done comes with the last vector's result
   assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_valid && res_vec == last_vec));
   // R8: sequencer is idle when done is shown
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/rcs_selftest_tb_top.sv
module rcs_selftest_tb_top;
   localparam int W  = 3;
   localparam int MG = 8;
   localparam int WW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    gate_cnt = '0;
   logic [MG*WW-1:0] prog_words = '0;
   logic          inj_en = 1'b0;
   logic [2:0]    inj_gate = '0;
   logic          inj_rev = 1'b0;
   logic [W-1:0]  inj_mask = '0;
   logic          busy, res_valid, res_flag, done, fault_sticky;
   logic [W-1:0]  res_vec, res_diff;

   int total = 0;
   int bad   = 0;
   int gk[MG], gt[MG], ga[MG], gb[MG];

   always #5 clk = ~clk;

   rcs_selftest #(.WIRES(W), .MAX_GATES(MG)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .gate_cnt(gate_cnt),
      .prog_words(prog_words), .inj_en(inj_en), .inj_gate(inj_gate),
      .inj_rev(inj_rev), .inj_mask(inj_mask), .busy(busy),
      .res_valid(res_valid), .res_vec(res_vec), .res_diff(res_diff),
      .res_flag(res_flag), .done(done), .fault_sticky(fault_sticky)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] gstep(input logic [W-1:0] s, input int g);
      logic [W-1:0] r;
      r = s;
      case (gk[g])
         0: r[gt[g]] = ~s[gt[g]];
         1: r[gt[g]] = s[gt[g]] ^ s[ga[g]];
         2: r[gt[g]] = s[gt[g]] ^ (s[ga[g]] & s[gb[g]]);
         default: if (s[ga[g]]) begin r[gt[g]] = s[gb[g]]; r[gb[g]] = s[gt[g]]; end
      endcase
      return r;
   endfunction

   function automatic logic [W-1:0] model(input logic [W-1:0] v, input int n,
         input bit en, input int ig, input bit irev, input logic [W-1:0] m);
      logic [W-1:0] s;
      s = v;
      for (int g = 0; g < n; g++) begin
         s = gstep(s, g);
         if (en && !irev && g == ig) s = s ^ m;
      end
      for (int g = n - 1; g >= 0; g--) begin
         s = gstep(s, g);
         if (en && irev && g == ig) s = s ^ m;
      end
      return s ^ v;
   endfunction

   task automatic set_gate(input int g, input int k, input int t, input int a, input int b);
      gk[g] = k; gt[g] = t; ga[g] = a; gb[g] = b;
      prog_words[g*WW +: WW] = {2'(b), 2'(a), 2'(t), 2'(k)};
   endtask

   task automatic do_run(input int n, input bit en, input int ig, input bit irev,
                         input logic [W-1:0] m, input bit poke);
      int cyc, last_t, cnt;
      logic [W-1:0] ev, ed;
      bit any, got_done;
      gate_cnt = 4'(n); inj_en = en; inj_gate = 3'(ig); inj_rev = irev; inj_mask = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 sticky cleared at start", fault_sticky, 0);
      ev = 3'd2; cyc = 0; last_t = -1; cnt = 0; any = 0; got_done = 0;
      while (!got_done && cyc < 500) begin
         @(negedge clk);
         cyc++;
         start = (poke && cyc == 3);
         if (res_valid) begin
            ed = model(ev, n, en, ig, irev, m);
            chk("R2 vector order", res_vec, ev);
            chk("R3 R4 R5 R6 difference word", res_diff, ed);
            chk("R5 flag", res_flag, (ed != 0));
            if (last_t >= 0) chk("R9 result spacing", cyc - last_t, 2*n + 1);
            last_t = cyc;
            any = any | (ed != 0);
            cnt++;
            if (done) begin
               got_done = 1;
               chk("R8 done on last vector", res_vec, 3'd6);
               chk("R8 busy low at done", busy, 0);
            end
            ev = ev + 3'd1;
         end else if (done) begin
            got_done = 1;
            chk("R8 done without result", 1, 0);
         end
      end
      start = 1'b0;
      chk("R8 done seen", got_done, 1);
      chk(poke ? "R10 count with start while busy" : "R2 vector count", cnt, 5);
      chk("R7 sticky after run", fault_sticky, any);
      @(negedge clk);
      chk("R8 no second done", done, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int g = 0; g < MG; g++) set_gate(g, 0, 0, 1, 2);
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      chk("R1 valid in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", done, 0);
      chk("R1 sticky after reset", fault_sticky, 0);
      chk("R1 busy after reset", busy, 0);

      // reference 6-gate, 3-wire program
      set_gate(0, 2, 2, 0, 1);
      set_gate(1, 1, 1, 0, 2);
      set_gate(2, 0, 0, 1, 2);
      set_gate(3, 3, 1, 2, 0);
      set_gate(4, 1, 2, 1, 0);
      set_gate(5, 2, 0, 1, 2);
      do_run(6, 0, 2, 0, 3'b111, 0);    // R4, R6 disabled mask has no effect
      do_run(6, 1, 2, 0, 3'b001, 0);    // R6 single flip forward
      do_run(6, 0, 0, 0, 3'b000, 0);    // R7 sticky clears
      do_run(6, 1, 5, 1, 3'b101, 0);    // R6 multi flip reverse
      do_run(6, 1, 0, 1, 3'b010, 0);    // R6 after last reverse gate
      do_run(6, 1, 7, 0, 3'b111, 0);    // R6 index beyond count
      do_run(0, 1, 0, 0, 3'b011, 0);    // R9 empty cascade
      do_run(6, 0, 0, 0, 3'b000, 1);    // R10 start while busy
      do_run(8, 1, 7, 1, 3'b100, 0);    // full-size program
      for (int r = 0; r < 20; r++) begin
         for (int g = 0; g < MG; g++) begin
            int t, a;
            t = $urandom % 3;
            a = (t + 1 + ($urandom % 2)) % 3;
            set_gate(g, $urandom % 4, t, a, 3 - t - a);
         end
         do_run($urandom % 9, ($urandom % 2) == 1, $urandom % 8,
                ($urandom % 2) == 1, 3'($urandom), 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule